// File: doc/BRIEF.md
# Dual-Timeout Service Watchdog

This block watches a service line driven by a processor and asks the reset generator for a system reset when the line stops changing. Each rising and each falling transition of the service line counts as a kick. A kick restarts the timer. The line is brought into the clock domain through a synchronizer. Transitions are found by comparing consecutive synchronized samples.

There are two timeout lengths, both set in clock cycles by parameters. A long window applies after every reset release, so that boot software has time to start. The first kick ends that window, and from then on the short window applies. When a window runs out, the block drives a single-cycle expiry pulse to the reset generator. It then sits idle until the next release.

While the reset-active input is high, the block is held in its idle state and the timer is clear. This covers power-up, manual and watchdog resets.

States and transitions:

- **IDLE**: waits for a release. `rst_release` moves it to BOOT.
- **BOOT**: counts toward the long limit.
  - A kick moves it to RUN.
  - Reaching the limit moves it to FIRED.
  - A release restarts BOOT.
- **RUN**: counts toward the short limit.
  - A kick clears the count and stays in RUN.
  - Reaching the limit moves it to FIRED.
  - A release moves it to BOOT.
- **FIRED**: lasts one cycle and drives the pulse. It then goes to IDLE, or to BOOT if a release arrives in that same cycle.
- **Any state**: `rst_active` forces IDLE, and this takes priority over every other transition.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_active` is 1, `expire_o` is 0 and the block is in IDLE. If `rst_active` falls and no `rst_release` pulse follows, no expiry is ever produced.
- R2: A one-cycle `rst_release` (with `rst_active` low) is sampled at clock edge E0 and enters BOOT. With no kick, `expire_o` is 1 for the cycle after edge E0+BOOT_CYC.
- R3: Inside the startup window, no expiry occurs before BOOT_CYC cycles, even though BOOT_CYC is greater than RUN_CYC.
- R4: A change of `svc_in` first sampled at edge k is acted on at edge k+2. In BOOT, this moves the block to RUN. With no further kick, `expire_o` is then 1 for the cycle after edge k+2+RUN_CYC.
- R5: Both a rising (0 to 1) and a falling (1 to 0) transition of `svc_in` count as a kick. Repeated kicks spaced under RUN_CYC cycles apart prevent any expiry.
- R6: A kick that is acted on at the same edge as the last count of the window clears the timer, and no expiry is produced at that edge.
- R7: The expiry pulse is exactly one cycle wide. After it, the block stays idle with `expire_o` at 0 until the next release, whatever `svc_in` does.
- R8: A release that arrives in RUN or in BOOT restarts the long startup window from zero.
- R9: `rst_active` during counting clears the timer. While `rst_active` is high, a `rst_release` pulse is ignored.
- R10: A level on `svc_in` held across a single sampling edge is recognised. A one-cycle high pulse therefore yields two kicks, one cycle apart.
- R11: Transitions of `svc_in` while in IDLE are ignored. A later release still starts the long window, not the short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_active | input | 1 | High while any system reset is asserted; synchronous clear |
| rst_release | input | 1 | One-cycle strobe marking reset release |
| svc_in | input | 1 | Asynchronous service (kick) line from the processor |
| expire_o | output | 1 | One-cycle expiry request to the reset generator |

## Verification
The bench aims at exact cycle boundaries:

- **Expiry edge.** It checks the expiry edge for both windows, counting the two synchronizer flops and the compare flop. A design with one register too many or too few would pulse a cycle late or early.
- **Kick on the final count.** It places a kick on the last counting edge. A design that gave the timeout priority over the kick would reset a processor that was serviced in time.
- **Both transition directions and short pulses.** It kicks with rising and with falling transitions, and with a one-cycle pulse. A design that detected only one direction would expire early, or expire while the processor is alive.
- **Idle-period edges and release handling.** It checks that edges seen while idle are ignored, that a release while running restores the long window, and that a release under an active reset is ignored. A mistake in any of these would either skip the boot allowance or arm the timer while reset is held.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_BOOT  = 2'd1,
        WD_RUN   = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic edge_o
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] the previous one
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        pipe[0] <= async_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe[g] <= pipe[g-1];
        end
    end

    assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];

endmodule

// File: rtl/wdg_cycle_timer.sv
module wdg_cycle_timer #(
    parameter int LONG_CYC  = 40,
    parameter int SHORT_CYC = 12
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic short_sel,
    output logic hit_o
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last  = short_sel ? SHORT_LAST : LONG_LAST;
    assign hit_o = en && (cnt == last);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_ctrl_fsm.sv
module wdg_ctrl_fsm
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_active,
    input  logic rst_release,
    input  logic svc_edge,
    input  logic tmr_hit,
    output logic tmr_clr,
    output logic tmr_en,
    output logic short_sel,
    output logic expire_o
);
    wd_state_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            WD_IDLE:  if (rst_release) nxt = WD_BOOT;
            WD_BOOT:  begin
                if (rst_release)   nxt = WD_BOOT;
                else if (svc_edge) nxt = WD_RUN;
                else if (tmr_hit)  nxt = WD_FIRED;
            end
            WD_RUN:   begin
                if (rst_release)   nxt = WD_BOOT;
                else if (svc_edge) nxt = WD_RUN;
                else if (tmr_hit)  nxt = WD_FIRED;
            end
            WD_FIRED: nxt = rst_release ? WD_BOOT : WD_IDLE;
            default:  nxt = WD_IDLE;
        endcase
        if (rst_active) nxt = WD_IDLE;
    end

    always_ff @(posedge clk) begin
        st <= nxt;
    end

    always_comb begin
        tmr_en    = (st == WD_BOOT) || (st == WD_RUN);
        short_sel = (st == WD_RUN);
        tmr_clr   = rst_active || rst_release || svc_edge || (nxt != st) || !tmr_en;
        expire_o  = (st == WD_FIRED);
    end

    p_idle_in_reset_r1: assert property (@(posedge clk) disable iff (rst_active)
        $past(rst_active) |-> (st == WD_IDLE && !expire_o));

    p_fire_from_window_r2: assert property (@(posedge clk) disable iff (rst_active)
        expire_o |-> ($past(st) == WD_BOOT || $past(st) == WD_RUN));

    p_kick_ends_boot_r4: assert property (@(posedge clk) disable iff (rst_active)
        (st == WD_BOOT && svc_edge && !rst_release) |=> (st == WD_RUN));

    p_kick_beats_limit_r6: assert property (@(posedge clk) disable iff (rst_active)
        (st == WD_RUN && svc_edge && !rst_release) |=> !expire_o);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst_active)
        expire_o |=> !expire_o);

    p_release_reboots_r8: assert property (@(posedge clk) disable iff (rst_active)
        rst_release |=> (st == WD_BOOT));

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
    parameter int BOOT_CYC    = 40,
    parameter int RUN_CYC     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_active,
    input  logic rst_release,
    input  logic svc_in,
    output logic expire_o
);
    logic svc_edge;
    logic tmr_clr;
    logic tmr_en;
    logic short_sel;
    logic tmr_hit;

    wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (svc_in),
        .edge_o   (svc_edge)
    );

    wdg_cycle_timer #(.LONG_CYC(BOOT_CYC), .SHORT_CYC(RUN_CYC)) u_timer (
        .clk       (clk),
        .clr       (tmr_clr),
        .en        (tmr_en),
        .short_sel (short_sel),
        .hit_o     (tmr_hit)
    );

    wdg_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_active  (rst_active),
        .rst_release (rst_release),
        .svc_edge    (svc_edge),
        .tmr_hit     (tmr_hit),
        .tmr_clr     (tmr_clr),
        .tmr_en      (tmr_en),
        .short_sel   (short_sel),
        .expire_o    (expire_o)
    );

endmodule

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BOOT = 40;
    localparam int RUN  = 12;

    logic clk = 1'b0;
    logic rst_active = 1'b1;
    logic rst_release = 1'b0;
    logic svc_in = 1'b0;
    logic expire_o;
    int n_checks = 0;
    int n_fail = 0;

    svc_watchdog #(.BOOT_CYC(BOOT), .RUN_CYC(RUN), .SYNC_STAGES(2)) u_dut (
        .clk (clk), .rst_active (rst_active), .rst_release (rst_release),
        .svc_in (svc_in), .expire_o (expire_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic release_pulse();
        rst_release = 1'b1;
        step();
        rst_release = 1'b0;
    endtask

    // expiry expected for the cycle after the n-th coming edge, then quiet
    task automatic expect_fire(input int n, input string tag);
        int early = 0;
        for (int i = 0; i < n - 1; i++) begin
            step();
            if (expire_o) early++;
        end
        check(early == 0, {tag, " no early expiry"}, early, 0);
        step();
        check(expire_o == 1'b1, {tag, " expiry edge"}, int'(expire_o), 1);
        step();
        check(expire_o == 1'b0, {tag, " pulse width"}, int'(expire_o), 0);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (expire_o) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 6; i++) step();
        check(expire_o == 1'b0, "R1 output in reset", int'(expire_o), 0);
        svc_in = ~svc_in;
        step();
        svc_in = ~svc_in;
        step();
        rst_active = 1'b0;
        expect_quiet(3 * BOOT, "R1 no expiry without release");
    endtask

    task automatic t_boot_timeout();
        release_pulse();
        expect_fire(BOOT, "R2 R3 boot window");
        expect_quiet(2 * BOOT, "R7 idle after pulse");
    endtask

    task automatic t_edge_kind(input logic start_val, input string tag);
        svc_in = start_val;
        for (int i = 0; i < 5; i++) step();
        release_pulse();
        for (int i = 0; i < 3; i++) step();
        svc_in = ~start_val;
        expect_fire(RUN + 3, tag);
    endtask

    task automatic t_steady_kicks();
        release_pulse();
        step();
        for (int k = 0; k < 6; k++) begin
            svc_in = ~svc_in;
            expect_quiet(RUN - 2, "R5 kicks keep alive");
        end
        svc_in = ~svc_in;
        expect_fire(RUN + 3, "R4 expiry after last kick");
    endtask

    task automatic t_last_cycle_kick();
        release_pulse();
        step();
        step();
        svc_in = ~svc_in;
        expect_quiet(RUN, "R6 before final count");
        svc_in = ~svc_in;
        expect_fire(RUN + 3, "R6 kick on final count");
    endtask

    task automatic t_release_in_run();
        release_pulse();
        step();
        svc_in = ~svc_in;
        for (int i = 0; i < 4; i++) step();
        release_pulse();
        expect_fire(BOOT, "R8 release restores long window");
    endtask

    task automatic t_reset_mid();
        release_pulse();
        for (int i = 0; i < 10; i++) step();
        rst_active = 1'b1;
        step();
        rst_release = 1'b1;
        step();
        rst_release = 1'b0;
        step();
        check(expire_o == 1'b0, "R9 output while held", int'(expire_o), 0);
        rst_active = 1'b0;
        expect_quiet(BOOT + 5, "R9 release under reset ignored");
        release_pulse();
        expect_fire(BOOT, "R9 fresh window after reset");
    endtask

    task automatic t_short_pulse();
        release_pulse();
        step();
        step();
        svc_in = ~svc_in;
        step();
        svc_in = ~svc_in;
        expect_fire(RUN + 3, "R10 one-cycle pulse gives two kicks");
    endtask

    task automatic t_idle_edges();
        for (int k = 0; k < 4; k++) begin
            svc_in = ~svc_in;
            step();
            step();
        end
        for (int i = 0; i < 4; i++) step();
        release_pulse();
        expect_fire(BOOT, "R11 idle edges ignored");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_boot_timeout();
        t_edge_kind(1'b0, "R5 R4 rising kick");
        t_edge_kind(1'b1, "R5 R4 falling kick");
        t_steady_kicks();
        t_last_cycle_kick();
        t_release_in_run();
        t_reset_mid();
        t_short_pulse();
        t_idle_edges();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule